// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Guard

This block protects 16-bit memory words with six check bits. On the write path it passes the processor's word to the memory side and adds five Hamming bits plus one overall parity bit. On the read path it takes a word and its stored check bits from memory and forms a syndrome. It repairs any single flipped bit in the data field, and it reports what it found on three error flags. Words returned to the processor carry one even-parity bit per byte.

Two read-timing styles can be selected for each read. In the watching style, the raw word reaches the processor in the same cycle that memory offers it, so a clean read costs no time. The flags settle one cycle later. When a data bit was wrong, the block then presents one extra corrected beat. In the hold style, the processor sees nothing until the word has been checked. Every read then returns exactly one cycle after the memory word is accepted, carrying corrected or unchanged data.

Top module: `ecc_core`

## Requirements
- R1: The write path forms `mem_wr_chk` as follows. Data bit i sits at the i-th position, counting up, of the codeword positions 1..21 that are not powers of two, so data bit 0 is at position 3 and data bit 15 is at position 21. Check bit k, for k = 0..4, is the XOR of all data bits whose position has bit k set. Check bit 5 is the XOR of all 16 data bits and check bits 0..4.
- R2: A read whose data and check bits agree gives flags {err_any, err_e1, err_e0} = 000 and returns the data unchanged.
- R3: A read with exactly one flipped data bit gives flags 111, and the returned corrected data equals the word that was written.
- R4: A read with exactly one flipped check bit, any of the six, gives flags 110, and the data is returned unchanged.
- R5: A read with exactly two flipped bits, in any mix of data and check bits, gives flags 100, and the data is returned exactly as read, with no bit altered.
- R6: The flags only ever hold 000, 110, 111 or 100.
- R7: Whenever `cpu_valid` is high, `cpu_par[b]` makes the count of ones in byte b of `cpu_data` together with `cpu_par[b]` even (byte 0 is bits 7:0).
- R8: With `hold_mode` = 1, `rd_ready` is high while the block is idle. `cpu_valid` rises exactly one cycle after a memory word is accepted, and both `cpu_valid` and `cpu_data` stay steady until `cpu_ready` is high. `rd_ready` stays low during that time.
- R9: With `hold_mode` = 0 and no correction pending, `cpu_valid` follows `rd_valid`, `cpu_data` equals `rd_data` in the same cycle, and `rd_ready` follows `cpu_ready`.
- R10: With `hold_mode` = 0, the flags for an accepted word appear in the next cycle. If they read 111, that cycle carries an extra beat with `cpu_valid` = 1, `cpu_fix` = 1 and the corrected data, and `rd_ready` stays low until that beat is taken. Otherwise no extra beat is produced.
- R11: The flags change only in the cycle after a memory word is accepted. An offered word that is not accepted does not change them, and they read 000 after reset.
- R12: The write handshake is passed straight through: `mem_wr_valid` = `wr_valid`, `wr_ready` = `mem_wr_ready`, and `mem_wr_data` = `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_mode | input | 1 | 1 = hold processor until checked, 0 = pass raw and watch |
| wr_valid | input | 1 | Processor write offer |
| wr_ready | output | 1 | Write accepted by memory side |
| wr_data | input | 16 | Word to be written |
| mem_wr_valid | output | 1 | Write offer to memory |
| mem_wr_ready | input | 1 | Memory can take the write |
| mem_wr_data | output | 16 | Word sent to memory |
| mem_wr_chk | output | 6 | Check bits sent to memory |
| rd_valid | input | 1 | Memory read word offered |
| rd_ready | output | 1 | Block takes the read word |
| rd_data | input | 16 | Word read from memory |
| rd_chk | input | 6 | Check bits read from memory |
| cpu_valid | output | 1 | Word offered to processor |
| cpu_ready | input | 1 | Processor takes the word |
| cpu_data | output | 16 | Word returned to processor |
| cpu_par | output | 2 | Even parity, one bit per byte |
| cpu_fix | output | 1 | This beat is a corrected repeat |
| err_any | output | 1 | Any error seen on last accepted read |
| err_e1 | output | 1 | Error flag E1 |
| err_e0 | output | 1 | Error flag E0 |

## Verification
Clean words such as all zeros, all ones and mixed patterns show whether the encoder and decoder agree on bit positions. A single flip is then swept across all 22 stored bits in each timing style. This separates a data-bit repair, where the word is restored and the flags read 111, from a check-bit hit, where the flags read 110 and the data is untouched, and it shows whether the watching style produces its extra beat only for the data case. A rotating set of double flips mixes data and check positions and confirms a 100 report with the read word left as it was. Back-pressure and unaccepted offers show that held output and held flags do not move.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W = 16;
    localparam int HAM_W  = 5;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CW_POS = DATA_W + HAM_W;
    localparam int BYTE_W = 8;
    localparam int NBYTES = DATA_W / BYTE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [HAM_W-1:0]  syn_t;

    typedef struct packed {
        logic any;
        logic e1;
        logic e0;
    } eflags_t;

    localparam eflags_t FL_NONE = 3'b000;
    localparam eflags_t FL_CHK  = 3'b110;
    localparam eflags_t FL_DATA = 3'b111;
    localparam eflags_t FL_DBL  = 3'b100;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HOLD,
        RS_WATCH
    } rstate_t;

    // Codeword position (1-based) of data bit idx: positions skip powers of two.
    function automatic syn_t data_pos(input int idx);
        int   seen;
        syn_t r;
        seen = 0;
        r    = '0;
        for (int p = 1; p <= CW_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) r = syn_t'(p);
                seen++;
            end
        end
        return r;
    endfunction

    // Data bits covered by Hamming bit k.
    function automatic word_t cover_mask(input int k);
        word_t m;
        syn_t  pos;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos  = data_pos(i);
            m[i] = pos[k];
        end
        return m;
    endfunction

    function automatic logic is_pow2(input syn_t s);
        return (s != '0) && ((s & (s - syn_t'(1))) == '0);
    endfunction

endpackage

// File: rtl/ecc_ham_gen.sv
module ecc_ham_gen
    import ecc_pkg::*;
(
    input  word_t data,
    output syn_t  ham
);
    for (genvar k = 0; k < HAM_W; k++) begin : g_bit
        localparam word_t MASK = cover_mask(k);
        assign ham[k] = ^(data & MASK);
    end
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
    import ecc_pkg::*;
(
    input  word_t   data,
    input  chk_t    chk,
    output word_t   fixed,
    output eflags_t flags
);
    syn_t  ham_now;
    syn_t  syn;
    logic  odd;
    word_t flip;

    ecc_ham_gen u_regen (
        .data (data),
        .ham  (ham_now)
    );

    assign syn = ham_now ^ chk[HAM_W-1:0];
    assign odd = ^{data, chk};

    always_comb begin
        if (!odd) begin
            flags = (syn == '0) ? FL_NONE : FL_DBL;
        end else if ((syn == '0) || is_pow2(syn)) begin
            flags = FL_CHK;
        end else if (int'(syn) <= CW_POS) begin
            flags = FL_DATA;
        end else begin
            flags = FL_DBL;
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam syn_t POS = data_pos(i);
        assign flip[i] = (flags == FL_DATA) && (syn == POS);
    end

    assign fixed = data ^ flip;
endmodule

// File: rtl/ecc_byte_par.sv
module ecc_byte_par
    import ecc_pkg::*;
(
    input  word_t             data,
    output logic [NBYTES-1:0] par
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign par[b] = ^data[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ecc_core.sv
module ecc_core
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_mode,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [CHK_W-1:0]  mem_wr_chk,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              cpu_valid,
    input  logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_data,
    output logic [NBYTES-1:0] cpu_par,
    output logic              cpu_fix,
    output logic              err_any,
    output logic              err_e1,
    output logic              err_e0
);
    // ---------------- write path ----------------
    syn_t wr_ham;

    ecc_ham_gen u_wgen (
        .data (wr_data),
        .ham  (wr_ham)
    );

    assign mem_wr_valid = wr_valid;
    assign wr_ready     = mem_wr_ready;
    assign mem_wr_data  = wr_data;
    assign mem_wr_chk   = {(^wr_data) ^ (^wr_ham), wr_ham};

    // ---------------- read path ----------------
    rstate_t st, st_nxt;
    word_t   held_data;
    chk_t    held_chk;
    word_t   fixed_data;
    eflags_t flags;
    word_t   out_data;
    logic    accept;

    ecc_decode u_dec (
        .data  (held_data),
        .chk   (held_chk),
        .fixed (fixed_data),
        .flags (flags)
    );

    assign accept = rd_valid && rd_ready;

    always_comb begin
        rd_ready  = 1'b0;
        cpu_valid = 1'b0;
        cpu_fix   = 1'b0;
        out_data  = rd_data;
        st_nxt    = st;
        if (st == RS_HOLD) begin
            cpu_valid = 1'b1;
            out_data  = fixed_data;
            if (cpu_ready) st_nxt = RS_IDLE;
        end else if ((st == RS_WATCH) && (flags == FL_DATA)) begin
            cpu_valid = 1'b1;
            cpu_fix   = 1'b1;
            out_data  = fixed_data;
            if (cpu_ready) st_nxt = RS_IDLE;
        end else if (hold_mode) begin
            rd_ready = 1'b1;
            st_nxt   = rd_valid ? RS_HOLD : RS_IDLE;
        end else begin
            rd_ready  = cpu_ready;
            cpu_valid = rd_valid;
            out_data  = rd_data;
            st_nxt    = (rd_valid && cpu_ready) ? RS_WATCH : RS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RS_IDLE;
            held_data <= '0;
            held_chk  <= '0;
        end else begin
            st <= st_nxt;
            if (accept) begin
                held_data <= rd_data;
                held_chk  <= rd_chk;
            end
        end
    end

    ecc_byte_par u_par (
        .data (out_data),
        .par  (cpu_par)
    );

    assign cpu_data = out_data;
    assign err_any  = flags.any;
    assign err_e1   = flags.e1;
    assign err_e0   = flags.e0;
endmodule

// File: rtl/ecc_core_chk.sv
module ecc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        hold_mode,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [15:0] rd_data,
    input logic        cpu_valid,
    input logic        cpu_ready,
    input logic [15:0] cpu_data,
    input logic [1:0]  cpu_par,
    input logic        cpu_fix,
    input logic        err_any,
    input logic        err_e1,
    input logic        err_e0
);
    assert_flag_code_R6: assert property (@(posedge clk) disable iff (rst)
        !(!err_any && (err_e1 || err_e0)) && !(err_any && !err_e1 && err_e0));

    assert_even_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |-> ((($countones({cpu_par[0], cpu_data[7:0]}) & 1) == 0) &&
                       (($countones({cpu_par[1], cpu_data[15:8]}) & 1) == 0)));

    assert_hold_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && hold_mode) |=> (cpu_valid && !rd_ready));

    assert_hold_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && !cpu_ready && hold_mode) |=> (cpu_valid && $stable(cpu_data)));

    assert_raw_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (!hold_mode && cpu_valid && !cpu_fix) |-> ((cpu_data == rd_data) && (rd_ready == cpu_ready)));

    assert_fix_beat_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_fix |-> (cpu_valid && !rd_ready && err_any && err_e1 && err_e0));

    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ready) |=> $stable({err_any, err_e1, err_e0}));
endmodule

bind ecc_core ecc_core_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .hold_mode (hold_mode),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_data  (cpu_data),
    .cpu_par   (cpu_par),
    .cpu_fix   (cpu_fix),
    .err_any   (err_any),
    .err_e1    (err_e1),
    .err_e0    (err_e0)
);

// File: tb/ecc_core_tb_top.sv
module ecc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_mode = 1'b1;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_data = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [15:0] mem_wr_data;
    logic [5:0]  mem_wr_chk;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [15:0] rd_data = '0;
    logic [5:0]  rd_chk = '0;
    logic        cpu_valid;
    logic        cpu_ready = 1'b0;
    logic [15:0] cpu_data;
    logic [1:0]  cpu_par;
    logic        cpu_fix;
    logic        err_any, err_e1, err_e0;

    int nvec  = 0;
    int nmiss = 0;

    always #5 clk = ~clk;

    ecc_core dut_i (
        .clk(clk), .rst(rst), .hold_mode(hold_mode),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_data(mem_wr_data), .mem_wr_chk(mem_wr_chk),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_chk(rd_chk),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_data(cpu_data),
        .cpu_par(cpu_par), .cpu_fix(cpu_fix),
        .err_any(err_any), .err_e1(err_e1), .err_e0(err_e0)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmiss++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference check bits built from the R1 layout.
    function automatic logic [5:0] ref_chk(input logic [15:0] d);
        logic [5:0] c;
        int di;
        c  = '0;
        di = 0;
        for (int p = 1; p <= 21; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < 5; k++) if (p[k]) c[k] = c[k] ^ d[di];
                di++;
            end
        end
        c[5] = (^d) ^ (^c[4:0]);
        return c;
    endfunction

    function automatic logic [1:0] ref_par(input logic [15:0] d);
        return {^d[15:8], ^d[7:0]};
    endfunction

    function automatic logic [2:0] ref_flags(input logic [21:0] m);
        if (m == '0) return 3'b000;
        if ($countones(m) >= 2) return 3'b100;
        if (m[15:0] != '0) return 3'b111;
        return 3'b110;
    endfunction

    function automatic string req_of(input logic [21:0] m);
        if (m == '0) return "R2";
        if ($countones(m) >= 2) return "R5";
        if (m[15:0] != '0) return "R3";
        return "R4";
    endfunction

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R11 reset flags", {29'b0, err_any, err_e1, err_e0}, 32'h0);
        chk("R8 reset idle ready", {31'b0, rd_ready}, 32'h1);
        chk("R8 reset no output", {31'b0, cpu_valid}, 32'h0);
    endtask

    task automatic t_write(input logic [15:0] d, input logic mrdy, output logic [5:0] c);
        @(negedge clk);
        wr_valid     = 1'b1;
        wr_data      = d;
        mem_wr_ready = mrdy;
        #1;
        chk("R1 check bits", {26'b0, mem_wr_chk}, {26'b0, ref_chk(d)});
        chk("R12 data pass", {16'b0, mem_wr_data}, {16'b0, d});
        chk("R12 handshake", {30'b0, mem_wr_valid, wr_ready}, {30'b0, 1'b1, mrdy});
        c = mem_wr_chk;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_read_hold(input logic [15:0] d, input logic [5:0] c,
                               input logic [21:0] m, input logic bp);
        logic [15:0] raw, expd;
        string       rq;
        raw  = d ^ m[15:0];
        expd = ($countones(m) >= 2) ? raw : d;
        rq   = req_of(m);
        @(negedge clk);
        hold_mode = 1'b1;
        rd_valid  = 1'b1;
        rd_data   = raw;
        rd_chk    = c ^ m[21:16];
        cpu_ready = !bp;
        #1;
        chk("R8 ready idle", {31'b0, rd_ready}, 32'h1);
        chk("R8 nothing yet", {31'b0, cpu_valid}, 32'h0);
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        chk("R8 valid after one", {30'b0, cpu_valid, rd_ready}, 32'h2);
        chk({rq, " data"}, {16'b0, cpu_data}, {16'b0, expd});
        chk({rq, " flags"}, {29'b0, err_any, err_e1, err_e0}, {29'b0, ref_flags(m)});
        chk("R7 parity", {30'b0, cpu_par}, {30'b0, ref_par(expd)});
        chk("R8 no fix beat", {31'b0, cpu_fix}, 32'h0);
        if (bp) begin
            @(negedge clk); #1;
            chk("R8 held under backpressure", {15'b0, cpu_valid, cpu_data}, {15'b0, 1'b1, expd});
            chk("R8 ready low while held", {31'b0, rd_ready}, 32'h0);
            cpu_ready = 1'b1;
        end
        @(negedge clk); #1;
        chk("R8 beat released", {31'b0, cpu_valid}, 32'h0);
    endtask

    task automatic t_read_watch(input logic [15:0] d, input logic [5:0] c, input logic [21:0] m);
        logic [15:0] raw;
        logic [2:0]  ef;
        string       rq;
        raw = d ^ m[15:0];
        ef  = ref_flags(m);
        rq  = req_of(m);
        @(negedge clk);
        hold_mode = 1'b0;
        rd_valid  = 1'b1;
        rd_data   = raw;
        rd_chk    = c ^ m[21:16];
        cpu_ready = 1'b1;
        #1;
        chk("R9 raw at once", {15'b0, cpu_valid, cpu_data}, {15'b0, 1'b1, raw});
        chk("R9 ready follows", {30'b0, rd_ready, cpu_fix}, 32'h2);
        chk("R7 raw parity", {30'b0, cpu_par}, {30'b0, ref_par(raw)});
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        chk({rq, " watch flags"}, {29'b0, err_any, err_e1, err_e0}, {29'b0, ef});
        if (ef == 3'b111) begin
            chk("R10 fix beat", {30'b0, cpu_valid, cpu_fix}, 32'h3);
            chk("R10 ready held", {31'b0, rd_ready}, 32'h0);
            chk("R3 fix data", {16'b0, cpu_data}, {16'b0, d});
            chk("R7 fix parity", {30'b0, cpu_par}, {30'b0, ref_par(d)});
            @(negedge clk); #1;
            chk("R10 fix taken", {31'b0, cpu_valid}, 32'h0);
        end else begin
            chk("R10 no extra beat", {31'b0, cpu_valid}, 32'h0);
        end
    endtask

    task automatic t_flag_hold(input logic [15:0] d, input logic [5:0] c);
        t_read_hold(d, c, 22'h1 << 4, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        chk("R11 idle hold", {29'b0, err_any, err_e1, err_e0}, 32'h7);
        @(negedge clk);
        hold_mode = 1'b0;
        cpu_ready = 1'b0;
        rd_valid  = 1'b1;
        rd_data   = d;
        rd_chk    = c;
        @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        chk("R11 unaccepted offer ignored", {29'b0, err_any, err_e1, err_e0}, 32'h7);
        cpu_ready = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nmiss++;
        nvec++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
        $finish;
    end

    initial begin
        logic [5:0] c;
        logic [15:0] pats [5];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
        pats[3] = 16'h1234; pats[4] = 16'h8001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();

        for (int p = 0; p < 5; p++) begin
            t_write(pats[p], p[0], c);
            t_read_hold(pats[p], c, '0, 1'b0);
            t_read_watch(pats[p], c, '0);
        end

        t_write(16'hA5C3, 1'b1, c);
        for (int f = 0; f < 22; f++) t_read_hold(16'hA5C3, c, 22'h1 << f, f[0]);

        t_write(16'h1234, 1'b1, c);
        for (int f = 0; f < 22; f++) t_read_watch(16'h1234, c, 22'h1 << f);

        t_write(16'h5A0F, 1'b1, c);
        for (int i = 0; i < 22; i++) begin
            int j;
            j = (i + 5 + (i % 3) * 4) % 22;
            t_read_hold(16'h5A0F, c, (22'h1 << i) | (22'h1 << j), 1'b0);
            t_read_watch(16'h5A0F, c, (22'h1 << i) | (22'h1 << ((i + 17) % 22)));
        end

        t_flag_hold(16'h5A0F, c);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
        $finish;
    end
endmodule